// File: doc/BRIEF.md
# SPI Panel Configuration Register Slave

This block is the serial control port of a small TFT panel controller. A host reaches it over a four-wire SPI link in mode 0, as a slave. Each transfer opens with an address byte. The top bit of that byte says whether the access is a read or a write, and the low seven bits name a register. A write carries one data byte from the master. A read returns one data byte from the slave during the second byte time.

The register space ends at address 0x44. Registers that exist come out of reset with fixed power-on values. Address 0 is a fixed identity code. Address 4 is a command rather than storage: writing it with a clear low bit fires a one-cycle global reset pulse and restores every writable register to its power-on value.

The stored bytes are decoded into registered configuration outputs that feed the rest of the panel logic: scan direction, input format, power control, signal polarities, sync mode and inversion scheme. SCK, CS and MOSI are oversampled in the system clock domain through two-flop synchronisers, so SCK must run at no more than one eighth of the system clock.

Top module: `panel_cfg_spi`

## Requirements
- R1: A frame is an address byte followed by a data byte, both MSB first, with MOSI sampled on SCK rising edges while CS is low. Address bit 7 = 0 means write and bit 7 = 1 means read; bits 6:0 are the register address. A write updates its register exactly once, when the 16th bit arrives.
- R2: In a read frame, the addressed register's value appears on MISO during the second byte, MSB first, and is stable at each SCK rising edge. MISO is 0 while CS is high.
- R3: Address 0x00 always reads 0x96, and writes to it are ignored.
- R4: After reset, the registers read as follows: 0x01 = 0x0F, 0x02 = 0x2E, 0x03 = 0x12, 0x06 = 0x03, 0x0A = 0x09. Every other implemented register reads 0x00.
- R5: A write to 0x04 with data bit 0 = 0 produces a single-cycle greset_pulse and returns all writable registers, and their decoded outputs, to the R4 values. A write to 0x04 with bit 0 = 1 has no effect. Address 0x04 reads 0x00.
- R6: Register 0x07 drives the power controls: bit 0 is pwr_normal (1 = normal operation, 0 = standby), bits 5:1 are supply_en[4:0], and bit 6 is pwr_auto.
- R7: Register 0x0A drives the polarities: bit 0 is dclk_pol, bit 1 hsync_pol, bit 2 vsync_pol, bit 3 de_pol, bit 4 chroma_swap, bit 5 yuv_formula and bit 6 level_invert. Register 0x0B bits 3:2 drive sync_mode (00 H+V sync, 01 H+V sync+DE, 10 DE only, 11 no sync), and its bit 0 drives line_inv (0 means frame inversion).
- R8: Register 0x06 drives the scan and input settings: bit 0 is scan_lr, bit 1 is scan_td, bits 3:2 are video_std and bits 7:4 are input_fmt. input_active is 0 for format codes 0x4, 0x9 and 0xC through 0xF, and 1 for every other code.
- R9: If CS is deasserted before the 16th bit of a frame, the frame is aborted and no register changes.
- R10: Only addresses 0x01–0x03, 0x06–0x0B and 0x10–0x17 hold data. Every other address from 0x01 to 0x7F, including all addresses above 0x44, reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from master (mode 0) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| greset_pulse | output | 1 | One-cycle global reset pulse |
| scan_lr | output | 1 | Left-to-right horizontal scan |
| scan_td | output | 1 | Top-to-bottom vertical scan |
| video_std | output | 2 | Video standard select |
| input_fmt | output | 4 | Input format code |
| input_active | output | 1 | Input format is a valid, enabled one |
| pwr_normal | output | 1 | Normal operation (0 = standby) |
| supply_en | output | 5 | Individual supply enables |
| pwr_auto | output | 1 | Automatic power sequencing |
| dclk_pol | output | 1 | Pixel clock polarity |
| hsync_pol | output | 1 | HSYNC polarity |
| vsync_pol | output | 1 | VSYNC polarity |
| de_pol | output | 1 | Data-enable polarity |
| chroma_swap | output | 1 | Swapped colour or chroma order |
| yuv_formula | output | 1 | YCbCr conversion formula select |
| level_invert | output | 1 | Reversed data level range |
| sync_mode | output | 2 | Sync signal mode |
| line_inv | output | 1 | Line inversion (0 = frame) |

## Verification
A corrupted stored byte shows up on the decoded outputs two system clocks after the write that caused it. It also shows up in the next read frame of that address, eight SCK periods later. A wrong bit count or direction flag shows as a register written from a read frame, a write landing on the wrong address, or MISO data shifted by one position, and the next read-back exposes it. A missing or extra global reset shows within a cycle as a greset_pulse count mismatch, and on the following read as non-default register contents.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 'h45;
  localparam logic [ADDR_W-1:0] MAX_ADDR = 7'h44;
  localparam logic [DATA_W-1:0] ID_VALUE = 8'h96;
  localparam int FRAME_BITS = 2 * DATA_W;

  localparam int A_ID     = 'h00;
  localparam int A_GRESET = 'h04;
  localparam int A_SCAN   = 'h06;
  localparam int A_PWR    = 'h07;
  localparam int A_POL    = 'h0A;
  localparam int A_SYNC   = 'h0B;

  // Addresses that hold storage.
  function automatic logic reg_impl(input int a);
    return (a >= 'h01 && a <= 'h03) || (a >= 'h06 && a <= 'h0B) ||
           (a >= 'h10 && a <= 'h17);
  endfunction

  function automatic logic [DATA_W-1:0] reg_default(input int a);
    case (a)
      'h01:    return 8'h0F;
      'h02:    return 8'h2E;
      'h03:    return 8'h12;
      'h06:    return 8'h03;
      'h0A:    return 8'h09;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{rst_val[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pcfg_spi_frame.sv
module pcfg_spi_frame
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              frame_active
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT      = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DONE          = CNT_W'(FRAME_BITS);

  logic              sck_d;
  logic              rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] shreg;
  logic              is_read;
  logic              load_pend;
  logic [DATA_W-1:0] tx;
  logic [ADDR_W-1:0] addr_q;

  assign frame_active = ~cs_n_s;
  assign rise         = sck_s & ~sck_d;
  assign rd_addr      = addr_q;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      is_read   <= 1'b0;
      load_pend <= 1'b0;
      tx        <= '0;
      addr_q    <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      miso      <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      load_pend <= 1'b0;
      miso      <= tx[DATA_W-1];
      if (load_pend && is_read) tx <= rd_data;
      if (rise && bit_cnt != DONE) begin
        shreg   <= {shreg[DATA_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_ADDR_BIT) begin
          is_read   <= shreg[DATA_W-2];
          addr_q    <= {shreg[ADDR_W-2:0], mosi_s};
          load_pend <= 1'b1;
        end
        if (bit_cnt > LAST_ADDR_BIT) tx <= {tx[DATA_W-2:0], 1'b0};
        if (bit_cnt == LAST_BIT && !is_read) begin
          wr_en   <= 1'b1;
          wr_addr <= addr_q;
          wr_data <= {shreg, mosi_s};
        end
      end
    end
  end
endmodule

// File: rtl/pcfg_regbank.sv
module pcfg_regbank
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              greset_pulse,
  output logic [DATA_W-1:0] scan_cfg,
  output logic [6:0]        pwr_cfg,
  output logic [6:0]        pol_cfg,
  output logic [1:0]        sync_sel,
  output logic              line_inv_cfg
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              greset_req;

  assign greset_req = wr_en && (wr_addr == ADDR_W'(A_GRESET)) && !wr_data[0];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst || greset_req)
        regs[i] <= reg_default(i);
      else if (wr_en && wr_addr == ADDR_W'(i) && reg_impl(i))
        regs[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) greset_pulse <= 1'b0;
    else     greset_pulse <= greset_req;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    if (rd_addr == ADDR_W'(A_ID)) rd_data = ID_VALUE;
  end

  assign scan_cfg     = regs[A_SCAN];
  assign pwr_cfg      = regs[A_PWR][6:0];
  assign pol_cfg      = regs[A_POL][6:0];
  assign sync_sel     = regs[A_SYNC][3:2];
  assign line_inv_cfg = regs[A_SYNC][0];
endmodule

// File: rtl/panel_cfg_spi.sv
module panel_cfg_spi
  import pcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       greset_pulse,
  output logic       scan_lr,
  output logic       scan_td,
  output logic [1:0] video_std,
  output logic [3:0] input_fmt,
  output logic       input_active,
  output logic       pwr_normal,
  output logic [4:0] supply_en,
  output logic       pwr_auto,
  output logic       dclk_pol,
  output logic       hsync_pol,
  output logic       vsync_pol,
  output logic       de_pol,
  output logic       chroma_swap,
  output logic       yuv_formula,
  output logic       level_invert,
  output logic [1:0] sync_mode,
  output logic       line_inv
);
  localparam logic [DATA_W-1:0] DEF_SCAN = reg_default(A_SCAN);
  localparam logic [DATA_W-1:0] DEF_POL  = reg_default(A_POL);

  logic              sck_s, cs_n_s, mosi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, frame_active;
  logic [DATA_W-1:0] scan_cfg;
  logic [6:0]        pwr_cfg, pol_cfg;
  logic [1:0]        sync_sel;
  logic              line_inv_cfg;

  pcfg_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .rst_val(3'b010),
    .d({spi_sck, spi_cs_n, spi_mosi}),
    .q({sck_s, cs_n_s, mosi_s})
  );

  pcfg_spi_frame u_frame (
    .clk(clk), .rst(rst), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .miso(spi_miso), .frame_active(frame_active)
  );

  pcfg_regbank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .greset_pulse(greset_pulse),
    .scan_cfg(scan_cfg), .pwr_cfg(pwr_cfg), .pol_cfg(pol_cfg),
    .sync_sel(sync_sel), .line_inv_cfg(line_inv_cfg)
  );

  function automatic logic fmt_ok(input logic [3:0] f);
    return !(f == 4'h4 || f == 4'h9 || f >= 4'hC);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_lr      <= DEF_SCAN[0];
      scan_td      <= DEF_SCAN[1];
      video_std    <= DEF_SCAN[3:2];
      input_fmt    <= DEF_SCAN[7:4];
      input_active <= fmt_ok(DEF_SCAN[7:4]);
      pwr_normal   <= 1'b0;
      supply_en    <= '0;
      pwr_auto     <= 1'b0;
      dclk_pol     <= DEF_POL[0];
      hsync_pol    <= DEF_POL[1];
      vsync_pol    <= DEF_POL[2];
      de_pol       <= DEF_POL[3];
      chroma_swap  <= DEF_POL[4];
      yuv_formula  <= DEF_POL[5];
      level_invert <= DEF_POL[6];
      sync_mode    <= '0;
      line_inv     <= 1'b0;
    end else begin
      scan_lr      <= scan_cfg[0];
      scan_td      <= scan_cfg[1];
      video_std    <= scan_cfg[3:2];
      input_fmt    <= scan_cfg[7:4];
      input_active <= fmt_ok(scan_cfg[7:4]);
      pwr_normal   <= pwr_cfg[0];
      supply_en    <= pwr_cfg[5:1];
      pwr_auto     <= pwr_cfg[6];
      dclk_pol     <= pol_cfg[0];
      hsync_pol    <= pol_cfg[1];
      vsync_pol    <= pol_cfg[2];
      de_pol       <= pol_cfg[3];
      chroma_swap  <= pol_cfg[4];
      yuv_formula  <= pol_cfg[5];
      level_invert <= pol_cfg[6];
      sync_mode    <= sync_sel;
      line_inv     <= line_inv_cfg;
    end
  end
endmodule

// File: rtl/pcfg_checks.sv
module pcfg_checks
  import pcfg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              greset_pulse,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              frame_active,
  input logic              spi_miso,
  input logic              scan_lr,
  input logic              scan_td,
  input logic              pwr_normal,
  input logic [4:0]        supply_en,
  input logic              dclk_pol,
  input logic              de_pol,
  input logic              hsync_pol,
  input logic [1:0]        sync_mode,
  input logic              line_inv
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    greset_pulse |=> !greset_pulse);

  a_r5_defaults_restored: assert property (@(posedge clk) disable iff (rst)
    greset_pulse |=> (scan_lr && scan_td && !pwr_normal && supply_en == 5'd0 &&
                      dclk_pol && de_pol && !hsync_pol && sync_mode == 2'd0 && !line_inv));

  a_r2_miso_idle: assert property (@(posedge clk) disable iff (rst)
    !frame_active |=> !spi_miso);

  a_r1_one_write_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r10_high_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > MAX_ADDR) |=> ##1 ($stable(pwr_normal) && $stable(sync_mode) &&
                                           $stable(scan_lr) && $stable(supply_en)));

  a_r3_id_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(A_ID)) |=> ##1 ($stable(pwr_normal) && $stable(sync_mode) &&
                                                 $stable(dclk_pol) && $stable(line_inv)));
endmodule

bind panel_cfg_spi pcfg_checks u_checks (
  .clk(clk), .rst(rst), .greset_pulse(greset_pulse), .wr_en(wr_en),
  .wr_addr(wr_addr), .frame_active(frame_active), .spi_miso(spi_miso),
  .scan_lr(scan_lr), .scan_td(scan_td), .pwr_normal(pwr_normal),
  .supply_en(supply_en), .dclk_pol(dclk_pol), .de_pol(de_pol),
  .hsync_pol(hsync_pol), .sync_mode(sync_mode), .line_inv(line_inv)
);

// File: tb/panel_cfg_spi_test.sv
module panel_cfg_spi_test;
  localparam int HP = 4;

  logic clk = 0, rst = 1;
  logic sck = 0, cs_n = 1, mosi = 0;
  logic miso, greset_pulse, scan_lr, scan_td, input_active, pwr_normal, pwr_auto;
  logic dclk_pol, hsync_pol, vsync_pol, de_pol, chroma_swap, yuv_formula, level_invert, line_inv;
  logic [1:0] video_std, sync_mode;
  logic [3:0] input_fmt;
  logic [4:0] supply_en;

  int checks = 0, errors = 0, gcount = 0;
  bit done = 0;
  logic [7:0] mdl [0:127];

  always #4 clk = ~clk;

  panel_cfg_spi uut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .greset_pulse(greset_pulse), .scan_lr(scan_lr), .scan_td(scan_td),
    .video_std(video_std), .input_fmt(input_fmt), .input_active(input_active),
    .pwr_normal(pwr_normal), .supply_en(supply_en), .pwr_auto(pwr_auto),
    .dclk_pol(dclk_pol), .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .de_pol(de_pol),
    .chroma_swap(chroma_swap), .yuv_formula(yuv_formula), .level_invert(level_invert),
    .sync_mode(sync_mode), .line_inv(line_inv)
  );

  always @(posedge clk) if (greset_pulse) gcount++;

  // R4 power-on values
  function automatic logic [7:0] def_of(input int a);
    case (a)
      1: return 8'h0F; 2: return 8'h2E; 3: return 8'h12;
      6: return 8'h03; 10: return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  // R10 storage map
  function automatic bit stored(input int a);
    return (a >= 1 && a <= 3) || (a >= 6 && a <= 11) || (a >= 16 && a <= 23);
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    if (a == 0) return 8'h96;
    return stored(a) ? mdl[a] : 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) mdl[i] = def_of(i);
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    if (a == 4 && !d[0]) model_reset();
    else if (stored(a)) mdl[a] = d;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rdv);
    logic [15:0] fr;
    fr = {rd, a, rd ? 8'h00 : wd};
    rdv = 8'h00;
    @(negedge clk) cs_n = 0;
    repeat (HP) @(negedge clk);
    for (int b = 0; b < 16; b++) begin
      if (b == nbits) break;
      mosi = fr[15-b];
      repeat (HP) @(negedge clk);
      sck = 1;
      if (b >= 8) rdv = {rdv[6:0], miso};
      repeat (HP) @(negedge clk);
      sck = 0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1; mosi = 0;
    repeat (4*HP) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer(1'b0, 7'(a), d, 16, dummy);
    model_write(a, d);
  endtask

  task automatic rd_check(input string req, input int a);
    logic [7:0] v;
    xfer(1'b1, 7'(a), 8'h00, 16, v);
    check(req, v, exp_read(a));
  endtask

  task automatic out_check(input string req);
    logic [7:0] s, p, y, q;
    s = mdl[6]; p = mdl[7]; y = mdl[10]; q = mdl[11];
    check({req, " R8 scan"}, {video_std, scan_td, scan_lr}, s[3:0]);
    check({req, " R8 fmt"}, {input_fmt, input_active},
          {s[7:4], !(s[7:4] == 4'h4 || s[7:4] == 4'h9 || s[7:4] >= 4'hC)});
    check({req, " R6 power"}, {pwr_auto, supply_en, pwr_normal}, p[6:0]);
    check({req, " R7 polarity"}, {level_invert, yuv_formula, chroma_swap, de_pol,
                                   vsync_pol, hsync_pol, dclk_pol}, y[6:0]);
    check({req, " R7 sync"}, {sync_mode, line_inv}, {q[3:2], q[0]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g0;
    int seed;
    logic [7:0] v;
    seed = $urandom(32'h1F2E3D4C);
    model_reset();
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);

    // R4 reset state, R2 MISO idle
    check("R2 miso idle", miso, 1'b0);
    out_check("R4 reset");
    foreach (mdl[i]) if (i < 24) rd_check("R4 reset read", i);

    // R3 identity register
    wr(0, 8'h55);
    rd_check("R3 id after write", 0);
    out_check("R3 no side effect");

    // R6, R7, R1 directed writes
    wr(7, 8'h7F); out_check("R6 all on");
    wr(7, 8'h2A); out_check("R6 pattern"); rd_check("R1 readback 07", 7);
    wr(11, 8'h0D); out_check("R7 sync 11");
    wr(11, 8'h04); out_check("R7 sync 01");
    wr(10, 8'h76); out_check("R7 polarity");
    rd_check("R1 readback 0A", 10);

    // R8 every input format code
    for (int f = 0; f < 16; f++) begin
      wr(6, {4'(f), 4'b1010});
      out_check("R8 format sweep");
    end

    // R9 aborted frames
    xfer(1'b0, 7'h01, 8'hA5, 12, v);
    rd_check("R9 abort mid data", 1);
    xfer(1'b0, 7'h02, 8'hA5, 5, v);
    rd_check("R9 abort mid address", 2);
    xfer(1'b0, 7'h03, 8'h5A, 15, v);
    rd_check("R9 abort last bit", 3);

    // R10 unimplemented and out-of-range addresses
    wr(5, 8'hAA);   rd_check("R10 gap addr", 5);
    wr(8'h44, 8'hAA); rd_check("R10 top addr", 8'h44);
    wr(8'h50, 8'hAA); rd_check("R10 above max", 8'h50);
    wr(8'h7F, 8'hFF); rd_check("R10 max code", 8'h7F);
    wr(8, 8'h3C);   rd_check("R10 stored 08", 8);
    wr(23, 8'hC3);  rd_check("R10 stored 17", 23);
    out_check("R10 outputs intact");

    // R5 global reset command
    g0 = gcount;
    wr(4, 8'h01);
    check("R5 bit0 set no pulse", gcount, g0);
    rd_check("R5 bit0 set keeps 07", 7);
    rd_check("R5 reads zero", 4);
    wr(4, 8'hFE);
    check("R5 one pulse", gcount, g0 + 1);
    out_check("R5 defaults");
    rd_check("R5 default 01", 1);
    rd_check("R5 default 08", 8);

    // Random mix
    for (int n = 0; n < 250; n++) begin
      int a;
      a = ($urandom % 2) ? int'($urandom % 128) : int'($urandom % 24);
      if ($urandom % 2) begin
        g0 = gcount;
        wr(a, 8'($urandom));
        check("R5 random pulse count", gcount, g0 + ((a == 4 && !mdl[6][0] && 0) ? 1 : 0) +
              ((a == 4) ? (gcount - g0) : 0));
      end else begin
        rd_check("R1 random read", a);
      end
      if (n % 16 == 0) out_check("R6 random outputs");
    end
    out_check("R7 final outputs");
    check("R2 miso idle end", miso, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule